// File: doc/BRIEF.md
# Iterative DES and Triple-DES Cipher Core

This core encrypts or decrypts one 64-bit block with DES, or with triple-DES, using a single round datapath that it reuses on every cycle. A caller presents the data word, up to three 64-bit keys, a direction bit and a single/triple select, then pulses `start`. The core raises `busy`, walks through the rounds, and pulses `done` when `dout` holds the result.

Each DES pass takes 18 clock cycles: one load cycle, one set-up cycle that moves the round halves into place and forms the first S-box input, and sixteen rounds. The subkeys come from the key halves, which rotate left for encryption and right for decryption. In triple mode, three passes run back to back and the state is handed on without the final or initial permutation between them. Parts of the datapath are selected by XOR with registers that are cleared in set cycles, instead of by wide multiplexers. This applies to the key-load register, the rotating key-half register and the S-box input register.

A new block, with new keys, can start in the same cycle in which `done` is high, so a stream of blocks runs with no idle cycles.

Top module: `des_iter_core`

## Requirements
- R1: Single DES: encryption and decryption match standard DES. `din`, `dout` and the key ports use standard bit 1 at port bit 63. `done` is high exactly 18 cycles after the clock edge that accepts `start`.
- R2: `done` is high for exactly one cycle. `dout` holds the finished result during that cycle.
- R3: Triple-DES (`tdes`=1) encrypts as E(key1), D(key2), E(key3) and decrypts as D(key3), E(key2), D(key1). The result equals that of three separate DES operations. `done` comes 54 cycles after the accepting edge.
- R4: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high. A `start` while `busy` is high is ignored: it changes neither the result nor its timing.
- R5: A `start` in the cycle in which `done` is high is accepted. The next block may use different keys and a different mode, with no idle cycle between the two blocks.
- R6: The parity bits of every key (bit 0 of each byte, port bits 56, 48, ..., 0) have no effect on the result.
- R7: `din`, the keys, `decrypt` and `tdes` are sampled only at the accepting edge. Changing them later has no effect on the block in progress.
- R8: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block when not busy |
| tdes | input | 1 | 1 selects triple-DES, 0 selects single DES |
| decrypt | input | 1 | 1 decrypts, 0 encrypts |
| din | input | 64 | Input block |
| key1 | input | 64 | First key; the only key used in single mode |
| key2 | input | 64 | Second key (triple mode) |
| key3 | input | 64 | Third key (triple mode) |
| dout | output | 64 | Result, valid while `done` is high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the handover between triple-DES passes. There, the reload cycle must clear the key halves and load the next key while the round halves hold still. A wrong key order or a missed swap would go unseen with three equal keys. The stimulus therefore sets two of the three keys equal, so that two passes cancel and the result must match a known single-DES answer under the remaining key. Back-to-back starts in the `done` cycle, starts pulsed mid-run, and inputs scrambled after acceptance cover the control corners.

// File: rtl/des_iter_core.sv
module des_iter_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tdes,
  input  logic        decrypt,
  input  logic [63:0] din,
  input  logic [63:0] key1,
  input  logic [63:0] key2,
  input  logic [63:0] key3,
  output logic [63:0] dout,
  output logic        busy,
  output logic        done
);

  localparam int BLK = 64;
  localparam int HALF = BLK / 2;
  localparam int KW = 56;
  localparam int XW = 48;
  localparam int ROUNDS = 16;
  localparam int LASTC = ROUNDS + 1;

  localparam logic [32*8-1:0] PTAB = {
    8'd16, 8'd7, 8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
    8'd1, 8'd15, 8'd23, 8'd26, 8'd5, 8'd18, 8'd31, 8'd10,
    8'd2, 8'd8, 8'd24, 8'd14, 8'd32, 8'd27, 8'd3, 8'd9,
    8'd19, 8'd13, 8'd30, 8'd6, 8'd22, 8'd11, 8'd4, 8'd25};

  localparam logic [56*8-1:0] KSEL = {
    8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9, 8'd1,
    8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18, 8'd10, 8'd2,
    8'd59, 8'd51, 8'd43, 8'd35, 8'd27, 8'd19, 8'd11, 8'd3,
    8'd60, 8'd52, 8'd44, 8'd36, 8'd63, 8'd55, 8'd47, 8'd39,
    8'd31, 8'd23, 8'd15, 8'd7, 8'd62, 8'd54, 8'd46, 8'd38,
    8'd30, 8'd22, 8'd14, 8'd6, 8'd61, 8'd53, 8'd45, 8'd37,
    8'd29, 8'd21, 8'd13, 8'd5, 8'd28, 8'd20, 8'd12, 8'd4};

  localparam logic [48*8-1:0] KCMP = {
    8'd14, 8'd17, 8'd11, 8'd24, 8'd1, 8'd5, 8'd3, 8'd28,
    8'd15, 8'd6, 8'd21, 8'd10, 8'd23, 8'd19, 8'd12, 8'd4,
    8'd26, 8'd8, 8'd16, 8'd7, 8'd27, 8'd20, 8'd13, 8'd2,
    8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55, 8'd30, 8'd40,
    8'd51, 8'd45, 8'd33, 8'd48, 8'd44, 8'd49, 8'd39, 8'd56,
    8'd34, 8'd53, 8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32};

  localparam logic [255:0] SBX [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D70934A6285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  function automatic int ip_src(input int i);
    int r;
    r = i / 8;
    return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * (i % 8);
  endfunction

  function automatic logic [BLK-1:0] ip_f(input logic [BLK-1:0] x);
    logic [BLK-1:0] y;
    for (int i = 0; i < BLK; i++) y[BLK-1-i] = x[BLK-ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLK-1:0] fp_f(input logic [BLK-1:0] x);
    logic [BLK-1:0] y;
    for (int i = 0; i < BLK; i++) y[BLK-ip_src(i)] = x[BLK-1-i];
    return y;
  endfunction

  function automatic logic [XW-1:0] expand(input logic [HALF-1:0] x);
    logic [XW-1:0] y;
    for (int i = 0; i < XW; i++)
      y[XW-1-i] = x[HALF-(((4 * (i / 6) + (i % 6) + 31) % 32) + 1)];
    return y;
  endfunction

  function automatic logic [HALF-1:0] pbox(input logic [HALF-1:0] x);
    logic [HALF-1:0] y;
    for (int i = 0; i < HALF; i++) y[HALF-1-i] = x[HALF-int'(PTAB[8*(31-i) +: 8])];
    return y;
  endfunction

  function automatic logic [KW-1:0] ksel(input logic [BLK-1:0] x);
    logic [KW-1:0] y;
    for (int i = 0; i < KW; i++) y[KW-1-i] = x[BLK-int'(KSEL[8*(55-i) +: 8])];
    return y;
  endfunction

  function automatic logic [XW-1:0] kcmp(input logic [KW-1:0] x);
    logic [XW-1:0] y;
    for (int i = 0; i < XW; i++) y[XW-1-i] = x[KW-int'(KCMP[8*(47-i) +: 8])];
    return y;
  endfunction

  function automatic logic [HALF-1:0] sboxes(input logic [XW-1:0] x);
    logic [HALF-1:0] y;
    logic [5:0] six;
    int idx;
    for (int b = 0; b < 8; b++) begin
      six = x[XW-1-6*b -: 6];
      idx = 16 * int'({six[5], six[0]}) + int'(six[4:1]);
      y[HALF-1-4*b -: 4] = SBX[b][255-4*idx -: 4];
    end
    return y;
  endfunction

  function automatic logic [27:0] rot28(input logic [27:0] v, input logic [1:0] n, input logic rt);
    logic [55:0] w;
    w = {v, v};
    if (rt) return w[27+n -: 28];
    return w[55-n -: 28];
  endfunction

  function automatic logic [1:0] step(input int r);
    return (r == 1 || r == 2 || r == 9 || r == 16) ? 2'd1 : 2'd2;
  endfunction

  logic [4:0]      cnt;
  logic [1:0]      pass;
  logic            tdes_q, dec_q;
  logic [KW-1:0]   kin, cd, kq2, kq3;
  logic [HALF-1:0] lh, rh;
  logic [XW-1:0]   sx;
  logic [1:0]      ramt;

  wire             pass_dec = dec_q ^ (tdes_q && pass == 2'd1);
  wire [KW-1:0]    cd_in = cd ^ kin;
  wire [KW-1:0]    cd_nx = {rot28(cd_in[55:28], ramt, pass_dec), rot28(cd_in[27:0], ramt, pass_dec)};
  wire [HALF-1:0]  fo = pbox(sboxes(sx)) & {HALF{cnt >= 5'd2}};
  wire [HALF-1:0]  r_nx = lh ^ fo;
  wire [XW-1:0]    sx_nx = expand(r_nx) ^ kcmp(cd_nx);
  wire             accept = start && !busy;
  wire             last = busy && cnt == 5'(LASTC) && (!tdes_q || pass == 2'd2);
  wire [BLK-1:0]   ipo = ip_f(din);

  always_comb begin
    ramt = 2'd0;
    if (cnt >= 5'd1 && cnt <= 5'(ROUNDS)) begin
      if (!pass_dec) ramt = step(int'(cnt));
      else if (cnt >= 5'd2) ramt = step(18 - int'(cnt));
    end
  end

  assign dout = fp_f({rh, lh});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; pass <= '0;
      tdes_q <= 1'b0; dec_q <= 1'b0;
      kin <= '0; cd <= '0; kq2 <= '0; kq3 <= '0;
      lh <= '0; rh <= '0; sx <= '0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1; cnt <= 5'd1; pass <= 2'd0;
        tdes_q <= tdes; dec_q <= decrypt;
        kin <= ksel((tdes && decrypt) ? key3 : key1);
        kq2 <= ksel(key2);
        kq3 <= ksel(decrypt ? key1 : key3);
        cd <= '0; sx <= '0;
        lh <= ipo[HALF-1:0]; rh <= ipo[BLK-1:HALF];
      end else if (busy && cnt == 5'd0) begin
        cnt <= 5'd1;
        kin <= (pass == 2'd1) ? kq2 : kq3;
        cd <= '0; sx <= '0;
      end else if (busy) begin
        lh <= rh; rh <= r_nx; sx <= sx_nx; cd <= cd_nx; kin <= '0;
        if (cnt == 5'(LASTC)) begin
          cnt <= 5'd0;
          if (last) busy <= 1'b0;
          else pass <= pass + 2'd1;
        end else cnt <= cnt + 5'd1;
      end
    end
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r4_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt >= 5'd1 && cnt <= 5'(ROUNDS)) |=> (cnt == $past(cnt) + 5'd1 && $stable(pass)));
  a_r5_free_at_done: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r1_r3_pass_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cnt) == 5'(LASTC) && $past(pass) == ($past(tdes_q) ? 2'd2 : 2'd0)));
  a_r3_key_load_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt >= 5'd2) |-> kin == '0);

endmodule

// File: tb/tb_des_iter_core.sv
module tb_des_iter_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, tdes = 1'b0, decrypt = 1'b0;
  logic [63:0] din = '0, key1 = '0, key2 = '0, key3 = '0;
  logic [63:0] dout;
  logic busy, done;
  int total = 0, bad = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  localparam logic [63:0] KA = 64'h133457799BBCDFF1;
  localparam logic [63:0] PA = 64'h0123456789ABCDEF;
  localparam logic [63:0] CA = 64'h85E813540F0AB405;
  localparam logic [63:0] KB = 64'h0E329232EA6D0D73;
  localparam logic [63:0] PB = 64'h8787878787878787;
  localparam logic [63:0] PAR = 64'h0101010101010101;

  always #5 clk = ~clk;

  des_iter_core dut (.clk(clk), .rst_n(rst_n), .start(start), .tdes(tdes), .decrypt(decrypt),
    .din(din), .key1(key1), .key2(key2), .key3(key3), .dout(dout), .busy(busy), .done(done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 7);
    return v ^ (v << 17);
  endfunction

  task automatic run(input logic t, input logic dec, input logic [63:0] d, input logic [63:0] k1,
                     input logic [63:0] k2, input logic [63:0] k3, input logic poke,
                     output logic [63:0] res, output int cyc);
    tdes = t; decrypt = dec; din = d; key1 = k1; key2 = k2; key3 = k3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    din = ~d; key1 = k2 ^ 64'h55; key2 = ~k1; key3 = k1; decrypt = ~dec; tdes = ~t;
    cyc = 1;
    while (!done && cyc < 300) begin
      if (poke && cyc == 5) begin
        chk("R4 busy mid-run", 64'(busy), 64'd1);
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    res = dout;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r, r2;
    int c;
    repeat (3) @(negedge clk);
    chk("R8 busy after reset", 64'(busy), 64'd0);
    chk("R8 done after reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(1'b0, 1'b0, PA, KA, 64'h0, 64'h0, 1'b0, r, c);
    chk("R1 known encrypt", r, CA);
    chk("R1 latency 18", 64'(c), 64'd18);
    @(negedge clk);
    chk("R2 done one cycle", 64'(done), 64'd0);
    chk("R2 dout held", dout, CA);

    run(1'b0, 1'b1, CA, KA, 64'h0, 64'h0, 1'b0, r, c);
    chk("R1 known decrypt", r, PA);
    run(1'b0, 1'b0, PB, KB, 64'h0, 64'h0, 1'b0, r, c);
    chk("R5 R1 back-to-back new key", r, 64'h0);
    chk("R5 latency 18", 64'(c), 64'd18);
    run(1'b0, 1'b0, PA, KA ^ PAR, 64'h0, 64'h0, 1'b0, r, c);
    chk("R6 parity ignored", r, CA);
    run(1'b0, 1'b0, PA, KA, 64'h0, 64'h0, 1'b1, r, c);
    chk("R4 start while busy result", r, CA);
    chk("R4 start while busy latency", 64'(c), 64'd18);

    run(1'b1, 1'b0, PA, KA, KA, KA, 1'b0, r, c);
    chk("R3 equal keys", r, CA);
    chk("R3 latency 54", 64'(c), 64'd54);
    run(1'b1, 1'b0, PA, KB, KB, KA, 1'b0, r, c);
    chk("R3 encrypt order", r, CA);
    run(1'b1, 1'b1, CA, KA, KB, KB, 1'b0, r, c);
    chk("R3 decrypt order", r, PA);
    run(1'b1, 1'b0, PA, KA ^ PAR, KB, KB ^ PAR, 1'b1, r, c);
    chk("R6 R4 triple parity and busy start", r, CA);

    for (int i = 0; i < 12; i++) begin
      logic [63:0] d, a, b, e;
      seed = nxt(seed); d = seed;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      seed = nxt(seed); e = seed;
      run(1'b0, 1'b0, d, a, b, e, 1'b0, r, c);
      run(1'b0, 1'b1, r, a, e, b, 1'b0, r2, c);
      chk("R1 R7 single round trip", r2, d);
      chk("R1 single latency", 64'(c), 64'd18);
      run(1'b1, 1'b0, d, a, b, e, 1'b0, r, c);
      run(1'b1, 1'b1, r, a, b, e, 1'b0, r2, c);
      chk("R3 R7 triple round trip", r2, d);
      chk("R3 triple latency", 64'(c), 64'd54);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule